// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block holds the match logic for two programmable alarms in a real-time clock. On each once-per-second update strobe it compares the current BCD time against the stored alarm settings and sets a sticky flag for each alarm that matches. An active-low, level-type interrupt output is driven from the flags, their enable bits and a global interrupt-mode bit.

The first alarm compares seconds, minutes, hours and a day/date field. The second alarm has no seconds setting and can only fire at second 00. Each stored field carries a mask bit (bit 7). A masked field is left out of the comparison, so an alarm can repeat every second, minute, hour, day or date. On the day/date setting, bit 6 chooses whether bits 5:0 are compared against the day of the week or the date of the month. Mask patterns outside the supported set never produce a match. The host clears a flag by writing 0 to its position. Writing 1 leaves the flag as it is.

The asynchronous reset input asserts at once and is released in step with the clock through a two-stage synchronizer.

Top module: `tod_alarm_match`

## Requirements
- R1: After reset both flags read 0 and `irq_n` reads 1.
- R2: Flags change only on a clock edge where `tick` is 1 or `flag_wr` is 1. A time that matches while `tick` is 0 sets no flag.
- R3: Alarm 1 mask bits are bit 7 of `{dd, hour, min, sec}`. The pattern 1111 matches every tick. Pattern 1110 compares seconds. Pattern 1100 compares seconds and minutes. Pattern 1000 compares seconds, minutes and hours. Pattern 0000 compares all four fields. Time fields are compared on bits 6:0.
- R4: Alarm 2 mask bits are bit 7 of `{dd, hour, min}`. It matches only when the seconds are 00. Pattern 111 then matches every minute. Pattern 110 adds minutes, pattern 100 adds hours, and pattern 000 adds the day/date field.
- R5: In a day/date setting, bit 6 = 0 compares bits 5:0 with `now_date`, and bit 6 = 1 compares bits 5:0 with `now_dow` (zero-extended).
- R6: Any other mask pattern (for example 1010 or 0111 on alarm 1) never matches.
- R7: A flag set by a match stays set. On a `flag_wr` cycle, a 0 in `flag_wdata` (bit 0 for alarm 1, bit 1 for alarm 2) clears that flag, and a 1 leaves it unchanged.
- R8: `irq_n` is 0 exactly when `int_ctl` is 1 and some flag is set with its enable bit at 1. It follows flag, enable and `int_ctl` changes without a clock delay.
- R9: If a match tick and a clearing write hit the same flag in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second update strobe; compare cycle |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours register bits 6:0 |
| now_dow | input | 3 | Current day of week |
| now_date | input | 6 | Current date of month, BCD |
| a1_sec_reg | input | 8 | Alarm 1 seconds: bit 7 mask, 6:0 value |
| a1_min_reg | input | 8 | Alarm 1 minutes: bit 7 mask, 6:0 value |
| a1_hour_reg | input | 8 | Alarm 1 hours: bit 7 mask, 6:0 value |
| a1_dd_reg | input | 8 | Alarm 1 day/date: bit 7 mask, bit 6 day select, 5:0 value |
| a2_min_reg | input | 8 | Alarm 2 minutes: bit 7 mask, 6:0 value |
| a2_hour_reg | input | 8 | Alarm 2 hours: bit 7 mask, 6:0 value |
| a2_dd_reg | input | 8 | Alarm 2 day/date: bit 7 mask, bit 6 day select, 5:0 value |
| a1_ie | input | 1 | Alarm 1 interrupt enable |
| a2_ie | input | 1 | Alarm 2 interrupt enable |
| int_ctl | input | 1 | Interrupt mode; 0 keeps `irq_n` high |
| flag_wr | input | 1 | Host write strobe for the flags |
| flag_wdata | input | 2 | Written flag values; 0 clears |
| a1_flag | output | 1 | Alarm 1 sticky flag |
| a2_flag | output | 1 | Alarm 2 sticky flag |
| irq_n | output | 1 | Active-low interrupt level |

## Verification
The bench walks alarm 1 through each legal mask depth. For each depth it moves the next-higher field just off and then onto its value, so a decoder that compared one field too many or too few would either miss the match or fire early. It sends two illegal patterns with every field equal, which an implementation that ignored the thermometer rule would flag. It runs alarm 2 at seconds other than 00 to catch a design that fires all minute long. It checks day versus date selection by making only one of the two targets agree. It also covers write-one-keeps, clear-versus-set collisions, and interrupt gating while a flag is held. A wrong priority or a missing enable term shows up there as a lost flag or a stuck `irq_n`.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int REG_W      = 8;
  localparam int TIME_W     = 7;
  localparam int DOW_W      = 3;
  localparam int DATE_W     = 6;
  localparam int MASK_POS   = 7;
  localparam int SEL_POS    = 6;
  localparam int NUM_ALARMS = 2;
  localparam int A1_FIELDS  = 4;
  localparam int A2_FIELDS  = 3;

  typedef struct packed {
    logic [TIME_W-1:0] sec;
    logic [TIME_W-1:0] min;
    logic [TIME_W-1:0] hour;
    logic [DOW_W-1:0]  dow;
    logic [DATE_W-1:0] date;
  } tod_t;
endpackage

// File: rtl/tod_alarm_mask_decode.sv
module tod_alarm_mask_decode #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] mask,
  output logic          legal,
  output logic [NF-1:0] cmp_en
);
  logic [NF-1:0] mask_up;

  // Legal masks are thermometer codes: once a field is masked,
  // every field above it is masked too.
  assign mask_up = mask << 1;
  assign legal   = ((mask | mask_up) == mask);
  assign cmp_en  = legal ? ~mask : '0;

  // R6: an illegal pattern enables no field comparison
  assert_illegal_no_cmp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[NF-1] == 1'b0 && mask != '0) |-> (cmp_en == '0));
endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
  import tod_alarm_pkg::*;
#(
  parameter int NF = A1_FIELDS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NF-2:0][REG_W-1:0]    al_tm,
  input  logic [REG_W-1:0]            al_dd,
  input  tod_t                        now,
  output logic                        match
);
  localparam int  NT      = NF - 1;
  localparam bit  HAS_SEC = (NF == A1_FIELDS);

  logic [NT-1:0][TIME_W-1:0] now_fld;
  logic [NF-1:0]             mask;
  logic [NF-1:0]             eq;
  logic [NF-1:0]             cmp_en;
  logic                      legal;
  logic                      day_sel;
  logic [DATE_W-1:0]         dd_val;
  logic                      dd_eq;
  logic                      sec_ok;

  generate
    if (HAS_SEC) begin : g_with_sec
      assign now_fld[0] = now.sec;
      assign now_fld[1] = now.min;
      assign now_fld[2] = now.hour;
      assign sec_ok     = 1'b1;
    end else begin : g_no_sec
      assign now_fld[0] = now.min;
      assign now_fld[1] = now.hour;
      assign sec_ok     = (now.sec == '0);
    end
  endgenerate

  generate
    for (genvar g = 0; g < NT; g++) begin : g_field
      assign mask[g] = al_tm[g][MASK_POS];
      assign eq[g]   = (al_tm[g][TIME_W-1:0] == now_fld[g]);
    end
  endgenerate

  assign day_sel  = al_dd[SEL_POS];
  assign dd_val   = al_dd[DATE_W-1:0];
  assign dd_eq    = day_sel ? (dd_val == {{(DATE_W-DOW_W){1'b0}}, now.dow})
                            : (dd_val == now.date);
  assign mask[NT] = al_dd[MASK_POS];
  assign eq[NT]   = dd_eq;

  tod_alarm_mask_decode #(.NF(NF)) u_decode (
    .clk    (clk),
    .rst_n  (rst_n),
    .mask   (mask),
    .legal  (legal),
    .cmp_en (cmp_en)
  );

  assign match = legal & sec_ok & (&(~cmp_en | eq));

  generate
    if (HAS_SEC) begin : g_chk_sec
      // R3: all fields masked matches on every evaluation
      assert_every_second_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> match);
    end else begin : g_chk_nosec
      // R4: second alarm can only match at second 00
      assert_min_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (now.sec == '0));
    end
  endgenerate
endmodule

// File: rtl/tod_alarm_flags.sv
module tod_alarm_flags #(
  parameter int NA = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [NA-1:0] match,
  input  logic          wr,
  input  logic [NA-1:0] wdata,
  input  logic [NA-1:0] ie,
  input  logic          int_ctl,
  output logic [NA-1:0] flag,
  output logic          irq_n
);
  logic [NA-1:0] flag_q;
  logic [NA-1:0] flag_d;
  logic [NA-1:0] set_now;
  logic [NA-1:0] clr_now;
  logic          flag_en;

  // Next-state: a match on the update tick has priority over a clear.
  always_comb begin
    for (int i = 0; i < NA; i++) begin
      set_now[i] = tick & match[i];
      clr_now[i] = wr & ~wdata[i];
      if (set_now[i])      flag_d[i] = 1'b1;
      else if (clr_now[i]) flag_d[i] = 1'b0;
      else                 flag_d[i] = flag_q[i];
    end
  end

  assign flag_en = tick | wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag  = flag_q;
  assign irq_n = ~(int_ctl & (|(flag_q & ie)));

  generate
    for (genvar g = 0; g < NA; g++) begin : g_chk
      // R9: a match tick always leaves the flag set
      assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && match[g]) |=> flag[g]);
      // R7: a zero write with no match clears the flag
      assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wdata[g] && !(tick && match[g])) |=> !flag[g]);
      // R2: a flag rises only after an update tick
      assert_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[g]) |-> $past(tick));
    end
  endgenerate

  // R8: interrupt mode off keeps the output released
  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !int_ctl |-> irq_n);
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [TIME_W-1:0] now_sec,
  input  logic [TIME_W-1:0] now_min,
  input  logic [TIME_W-1:0] now_hour,
  input  logic [DOW_W-1:0]  now_dow,
  input  logic [DATE_W-1:0] now_date,
  input  logic [REG_W-1:0]  a1_sec_reg,
  input  logic [REG_W-1:0]  a1_min_reg,
  input  logic [REG_W-1:0]  a1_hour_reg,
  input  logic [REG_W-1:0]  a1_dd_reg,
  input  logic [REG_W-1:0]  a2_min_reg,
  input  logic [REG_W-1:0]  a2_hour_reg,
  input  logic [REG_W-1:0]  a2_dd_reg,
  input  logic              a1_ie,
  input  logic              a2_ie,
  input  logic              int_ctl,
  input  logic              flag_wr,
  input  logic [1:0]        flag_wdata,
  output logic              a1_flag,
  output logic              a2_flag,
  output logic              irq_n
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_int;
  tod_t                   now;
  logic [A1_FIELDS-2:0][REG_W-1:0] a1_tm;
  logic [A2_FIELDS-2:0][REG_W-1:0] a2_tm;
  logic [NUM_ALARMS-1:0]  hit;
  logic [NUM_ALARMS-1:0]  ie_vec;
  logic [NUM_ALARMS-1:0]  flag_vec;

  // Reset asserts asynchronously and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe[SYNC_STAGES-1];

  assign now.sec  = now_sec;
  assign now.min  = now_min;
  assign now.hour = now_hour;
  assign now.dow  = now_dow;
  assign now.date = now_date;

  assign a1_tm[0] = a1_sec_reg;
  assign a1_tm[1] = a1_min_reg;
  assign a1_tm[2] = a1_hour_reg;
  assign a2_tm[0] = a2_min_reg;
  assign a2_tm[1] = a2_hour_reg;

  tod_alarm_unit #(.NF(A1_FIELDS)) u_alarm1 (
    .clk   (clk),
    .rst_n (rst_n_int),
    .al_tm (a1_tm),
    .al_dd (a1_dd_reg),
    .now   (now),
    .match (hit[0])
  );

  tod_alarm_unit #(.NF(A2_FIELDS)) u_alarm2 (
    .clk   (clk),
    .rst_n (rst_n_int),
    .al_tm (a2_tm),
    .al_dd (a2_dd_reg),
    .now   (now),
    .match (hit[1])
  );

  assign ie_vec = {a2_ie, a1_ie};

  tod_alarm_flags #(.NA(NUM_ALARMS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .tick    (tick),
    .match   (hit),
    .wr      (flag_wr),
    .wdata   (flag_wdata),
    .ie      (ie_vec),
    .int_ctl (int_ctl),
    .flag    (flag_vec),
    .irq_n   (irq_n)
  );

  assign a1_flag = flag_vec[0];
  assign a2_flag = flag_vec[1];

  // R1: while reset is held internally, nothing is flagged
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n_int |=> (!rst_n_int || (!a1_flag && !a2_flag)) || $past(tick));
endmodule

// File: tb/tod_alarm_match_bench.sv
module tod_alarm_match_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic       rst_n, tick, a1_ie, a2_ie, int_ctl, flag_wr;
  logic [6:0] now_sec, now_min, now_hour;
  logic [2:0] now_dow;
  logic [5:0] now_date;
  logic [7:0] a1_sec_reg, a1_min_reg, a1_hour_reg, a1_dd_reg;
  logic [7:0] a2_min_reg, a2_hour_reg, a2_dd_reg;
  logic [1:0] flag_wdata;
  logic       a1_flag, a2_flag, irq_n;

  tod_alarm_match u_tod_alarm_match (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_dow(now_dow), .now_date(now_date),
    .a1_sec_reg(a1_sec_reg), .a1_min_reg(a1_min_reg),
    .a1_hour_reg(a1_hour_reg), .a1_dd_reg(a1_dd_reg),
    .a2_min_reg(a2_min_reg), .a2_hour_reg(a2_hour_reg), .a2_dd_reg(a2_dd_reg),
    .a1_ie(a1_ie), .a2_ie(a2_ie), .int_ctl(int_ctl),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .a1_flag(a1_flag), .a2_flag(a2_flag), .irq_n(irq_n)
  );

  int n_chk  = 0;
  int n_fail = 0;

  typedef struct {
    bit    a1;
    bit    a2;
    bit    irqn;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic check1(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check_all(string tag, bit e1, bit e2, bit ei);
    check1({tag, " a1_flag"}, a1_flag, e1);
    check1({tag, " a2_flag"}, a2_flag, e2);
    check1({tag, " irq_n"},   irq_n,   ei);
  endtask

  // Driver: one update tick, expectation queued for the monitor.
  task automatic do_tick(bit e1, bit e2, bit ei, string tag);
    @(negedge clk);
    tick = 1'b1;
    sb_q.push_back('{e1, e2, ei, tag});
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_tick_clr(bit e1, bit e2, bit ei, string tag);
    @(negedge clk);
    tick       = 1'b1;
    flag_wr    = 1'b1;
    flag_wdata = 2'b00;
    sb_q.push_back('{e1, e2, ei, tag});
    @(negedge clk);
    tick    = 1'b0;
    flag_wr = 1'b0;
  endtask

  task automatic wr_flags(logic [1:0] wd);
    @(negedge clk);
    flag_wr    = 1'b1;
    flag_wdata = wd;
    @(negedge clk);
    flag_wr = 1'b0;
  endtask

  task automatic peek(bit e1, bit e2, bit ei, string tag);
    @(negedge clk);
    #1;
    check_all(tag, e1, e2, ei);
  endtask

  // Monitor: after each tick edge, compare against the queue head.
  initial begin
    forever begin
      @(posedge clk);
      if (tick === 1'b1) begin
        exp_t e;
        #(CLK_P/4);
        if (sb_q.size() == 0) begin
          n_chk++;
          n_fail++;
          $display("FAIL scoreboard: actual tick with empty queue expected none");
        end else begin
          e = sb_q.pop_front();
          check_all(e.tag, e.a1, e.a2, e.irqn);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic set_a1(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] d);
    a1_sec_reg = s; a1_min_reg = m; a1_hour_reg = h; a1_dd_reg = d;
  endtask

  task automatic set_a2(logic [7:0] m, logic [7:0] h, logic [7:0] d);
    a2_min_reg = m; a2_hour_reg = h; a2_dd_reg = d;
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; flag_wr = 1'b0; flag_wdata = 2'b11;
    a1_ie = 1'b1; a2_ie = 1'b0; int_ctl = 1'b1;
    now_sec = 7'h12; now_min = 7'h34; now_hour = 7'h10; now_dow = 3'd3; now_date = 6'h15;
    set_a1(8'h00, 8'h00, 8'h00, 8'h00);
    set_a2(8'h59, 8'h23, 8'h31);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    peek(0, 0, 1, "R1 reset state");

    // R2: matching settings without a tick
    set_a1(8'h80, 8'h80, 8'h80, 8'h80);
    repeat (5) @(negedge clk);
    peek(0, 0, 1, "R2 no tick no flag");

    // R3: every second, then clear (R7)
    do_tick(1, 0, 0, "R3 every second");
    wr_flags(2'b00);
    peek(0, 0, 1, "R7 clear by zero");

    // R3: seconds match
    set_a1(8'h30, 8'h80, 8'h80, 8'h80);
    now_sec = 7'h29;
    do_tick(0, 0, 1, "R3 seconds differ");
    now_sec = 7'h30;
    do_tick(1, 0, 0, "R3 seconds equal");
    wr_flags(2'b11);
    peek(1, 0, 0, "R7 write one keeps");
    wr_flags(2'b10);
    peek(0, 0, 1, "R7 clear alarm1 only");

    // R3: minutes and seconds
    set_a1(8'h30, 8'h34, 8'h80, 8'h80);
    now_min = 7'h35;
    do_tick(0, 0, 1, "R3 minutes differ");
    now_min = 7'h34;
    do_tick(1, 0, 0, "R3 minutes equal");
    wr_flags(2'b00);

    // R3: hours, minutes and seconds
    set_a1(8'h30, 8'h34, 8'h10, 8'h80);
    now_hour = 7'h11;
    do_tick(0, 0, 1, "R3 hours differ");
    now_hour = 7'h10;
    do_tick(1, 0, 0, "R3 hours equal");
    wr_flags(2'b00);

    // R5: date of month
    set_a1(8'h30, 8'h34, 8'h10, 8'h15);
    do_tick(1, 0, 0, "R5 date equal");
    wr_flags(2'b00);
    now_date = 6'h16;
    do_tick(0, 0, 1, "R5 date differs");

    // R5: day of week
    a1_dd_reg = 8'h43;
    do_tick(1, 0, 0, "R5 day equal date differs");
    wr_flags(2'b00);
    now_dow = 3'd4;
    do_tick(0, 0, 1, "R5 day differs");
    now_dow = 3'd3;

    // R6: illegal mask patterns with every value equal
    set_a1(8'h30, 8'hB4, 8'h10, 8'h80);
    do_tick(0, 0, 1, "R6 pattern 1010");
    set_a1(8'hB0, 8'hB4, 8'h90, 8'h43);
    do_tick(0, 0, 1, "R6 pattern 0111");

    // R4: once per minute; R8 gating
    set_a2(8'h80, 8'h80, 8'h80);
    now_sec = 7'h00;
    do_tick(0, 1, 1, "R8 flag set enable off");
    @(negedge clk);
    a2_ie = 1'b1;
    peek(0, 1, 0, "R8 enable on");
    int_ctl = 1'b0;
    peek(0, 1, 1, "R8 interrupt mode off");
    int_ctl = 1'b1;
    wr_flags(2'b01);
    peek(0, 0, 1, "R8 released after clear");
    now_sec = 7'h01;
    do_tick(0, 0, 1, "R4 nonzero second");

    // R4: minutes
    set_a2(8'h34, 8'h80, 8'h80);
    now_sec = 7'h00;
    do_tick(0, 1, 0, "R4 minutes equal");
    wr_flags(2'b00);
    now_min = 7'h35;
    do_tick(0, 0, 1, "R4 minutes differ");
    now_min = 7'h34;
    now_sec = 7'h05;
    do_tick(0, 0, 1, "R4 minute match off second 00");
    now_sec = 7'h00;

    // R4: hours and minutes
    set_a2(8'h34, 8'h10, 8'h80);
    now_hour = 7'h11;
    do_tick(0, 0, 1, "R4 hours differ");
    now_hour = 7'h10;
    do_tick(0, 1, 0, "R4 hours equal");
    wr_flags(2'b00);

    // R5 on alarm 2
    a2_dd_reg = 8'h43;
    do_tick(0, 1, 0, "R5 alarm2 day");
    wr_flags(2'b00);
    a2_dd_reg = 8'h16;
    do_tick(0, 1, 0, "R5 alarm2 date");
    wr_flags(2'b00);

    // R9: clear and match together
    do_tick_clr(0, 1, 0, "R9 set wins over clear");
    wr_flags(2'b00);
    peek(0, 0, 1, "R7 cleared after collision");

    // Both alarms at once
    set_a1(8'h80, 8'h80, 8'h80, 8'h80);
    do_tick(1, 1, 0, "R3 both alarms");
    a1_ie = 1'b0;
    peek(1, 1, 0, "R8 one enable suffices");

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule